// File: doc/BRIEF.md
# PAM-3 Transmit Compliance Pattern Generator

This block sits just ahead of the line driver in a 100 Mb/s single-pair Ethernet transmitter. It supplies one ternary symbol per symbol strobe, nominally every 15 ns. A 3-bit mode input picks the source of the symbols. The source is either the normal data stream from the PCS or one of four electrical test patterns:

- a long-run square wave for measuring droop;
- an alternating sequence for measuring jitter;
- a pseudo-random sequence with a 2047-symbol period for measuring distortion;
- a long-period random sequence for measuring spectral density.

Once a test pattern is selected, it runs without end. It starts again from its first symbol only when a different mode code is seen at a strobe, or when reset is applied. The generator has no receive-side input, so nothing arriving on the line can disturb the pattern. Each emitted symbol is flagged by a one-cycle valid pulse.

Top module: `pam3_tx_pattern_gen`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, `sym_out` is 2'b00 and `sym_vld` is 0. The active mode after reset is pass-through (code 0).
- R2: Each cycle with `sym_en` high loads a new symbol into `sym_out` at that clock edge, and `sym_vld` is high for exactly the following cycle. Without a strobe, `sym_out` holds its value and `sym_vld` is low.
- R3: Symbol encoding is two's complement: +1 = 2'b01, 0 = 2'b00, -1 = 2'b11. Mode codes are 0 pass-through, 1 droop, 2 jitter, 4 distortion and 5 random. In every test mode, 2'b10 is never emitted.
- R4: In mode 0, the symbol loaded at a strobe equals `data_in` at that strobe.
- R5: In mode 1, the output is HALF_LEN +1 symbols followed by HALF_LEN -1 symbols, and this repeats. HALF_LEN defaults to 34 and is rejected at elaboration if it is below 34.
- R6: In mode 2, the first symbol is -1, and every later symbol is the opposite of the one before it.
- R7: Mode 4 uses an 11-bit register s, seeded to 11'h001 on mode entry. Each symbol is mapped from s[1:0] (00 to 0, 01 to +1, 10 to -1, 11 to 0). After each symbol, s becomes {s[9:0], s[10]^s[8]}. The symbol stream repeats every 2047 symbols.
- R8: Mode 5 uses the same mapping on a 33-bit register, seeded to 33'h1 on mode entry. Its step is {s[31:0], s[32]^s[19]}. Its stream does not repeat with a 2047-symbol period.
- R9: Mode codes 3, 6 and 7 emit constant 0 symbols.
- R10: A mode change takes effect at the next strobe, and the new pattern starts from its first symbol. A code that is applied and then withdrawn between two strobes has no effect on the running pattern.
- R11: Gaps of any length between strobes do not alter the symbol sequence of a test mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_en | input | 1 | Symbol strobe; advances the output by one symbol |
| mode_sel | input | 3 | Mode code, sampled at each strobe |
| data_in | input | 2 | Normal-data symbol used in pass-through mode |
| sym_out | output | 2 | Current transmit symbol |
| sym_vld | output | 1 | High for one cycle after each strobe |

## Verification
Each test mode is run for more than one full period, and the stream is compared with a model built from the stated step rules.

- The 2047-symbol distortion stream is checked for exact self-repetition. The random stream is checked for the absence of that repetition, which tells the short and the long register apart.
- Irregular strobe gaps are placed inside the droop run. This separates a pattern that advances per strobe from one that advances per clock.
- The mode-switch sequences separate a restart on entry from a continuation. They include a code that is applied and withdrawn between strobes, which must leave the jitter alternation intact.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

   typedef logic [1:0] sym_t;

   localparam sym_t SYM_ZERO = 2'b00;
   localparam sym_t SYM_POS  = 2'b01;
   localparam sym_t SYM_NEG  = 2'b11;

   localparam int MODE_W = 3;
   typedef logic [MODE_W-1:0] mode_t;

   localparam mode_t MODE_PASS   = 3'd0;
   localparam mode_t MODE_DROOP  = 3'd1;
   localparam mode_t MODE_JITTER = 3'd2;
   localparam mode_t MODE_DIST   = 3'd4;
   localparam mode_t MODE_RAND   = 3'd5;

   // two register bits select one ternary level
   function automatic sym_t pair_to_sym(input logic [1:0] b);
      case (b)
         2'b01:   return SYM_POS;
         2'b10:   return SYM_NEG;
         default: return SYM_ZERO;
      endcase
   endfunction

endpackage

// File: rtl/tpg_droop.sv
module tpg_droop
   import tpg_pkg::*;
#(
   parameter int HALF_LEN = 34,
   parameter int MIN_HALF = 34
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic restart,
   output sym_t sym
);

   localparam int PERIOD = 2 * HALF_LEN;
   localparam int CW     = $clog2(PERIOD);
   localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
   localparam logic [CW-1:0] HALF  = CW'(HALF_LEN);

   generate
      if (HALF_LEN < MIN_HALF) begin : g_half_too_short
         $error("tpg_droop: HALF_LEN below the minimum run length");
      end
   endgenerate

   logic [CW-1:0] idx;
   logic [CW-1:0] base;
   logic [CW-1:0] idx_nxt;

   always_comb begin
      base    = restart ? '0 : idx;
      sym     = (base < HALF) ? SYM_POS : SYM_NEG;
      idx_nxt = (base == LAST) ? '0 : base + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= '0;
      else if (adv) idx <= idx_nxt;
   end

   AST_DROOP_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST); // R5

   AST_DROOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !restart && idx == LAST) |=> idx == '0); // R5

endmodule

// File: rtl/tpg_lfsr.sv
module tpg_lfsr
   import tpg_pkg::*;
#(
   parameter int WIDTH = 11,
   parameter int TAP   = 8,
   parameter logic [WIDTH-1:0] SEED = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic restart,
   output sym_t sym
);

   generate
      if (WIDTH < 3) begin : g_width_bad
         $error("tpg_lfsr: WIDTH must be at least 3");
      end
      if (TAP < 0 || TAP >= WIDTH - 1) begin : g_tap_bad
         $error("tpg_lfsr: TAP must lie below the top bit");
      end
      if (SEED == '0) begin : g_seed_bad
         $error("tpg_lfsr: SEED must be non-zero");
      end
   endgenerate

   logic [WIDTH-1:0] st;
   logic [WIDTH-1:0] base;
   logic [WIDTH-1:0] stepd;

   assign base = restart ? SEED : st;
   assign sym  = pair_to_sym(base[1:0]);

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_shift
         if (gi == 0) begin : g_fb
            assign stepd[gi] = base[WIDTH-1] ^ base[TAP];
         end else begin : g_mv
            assign stepd[gi] = base[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st <= SEED;
      else if (adv) st <= stepd;
   end

   AST_LFSR_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      st != '0); // R7

   AST_LFSR_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && restart) |=> st[WIDTH-1:1] == SEED[WIDTH-2:0]); // R10

endmodule

// File: rtl/pam3_tx_pattern_gen.sv
module pam3_tx_pattern_gen
   import tpg_pkg::*;
#(
   parameter int HALF_LEN = 34,
   parameter int DIST_W   = 11,
   parameter int DIST_TAP = 8,
   parameter logic [DIST_W-1:0] DIST_SEED = 1,
   parameter int RAND_W   = 33,
   parameter int RAND_TAP = 19,
   parameter logic [RAND_W-1:0] RAND_SEED = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sym_en,
   input  logic [2:0] mode_sel,
   input  logic [1:0] data_in,
   output logic [1:0] sym_out,
   output logic       sym_vld
);

   generate
      if (RAND_W <= DIST_W) begin : g_rand_short
         $error("pam3_tx_pattern_gen: random register must exceed distortion register");
      end
   endgenerate

   mode_t mode_q;
   logic  chg;
   sym_t  droop_sym, dist_sym, rand_sym, jit_sym, nxt_sym;
   logic  jit_tog;

   assign chg = (mode_sel != mode_q);

   tpg_droop #(
      .HALF_LEN (HALF_LEN)
   ) i_droop (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (sym_en && mode_sel == MODE_DROOP),
      .restart (chg),
      .sym     (droop_sym)
   );

   tpg_lfsr #(
      .WIDTH (DIST_W),
      .TAP   (DIST_TAP),
      .SEED  (DIST_SEED)
   ) i_dist (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (sym_en && mode_sel == MODE_DIST),
      .restart (chg),
      .sym     (dist_sym)
   );

   tpg_lfsr #(
      .WIDTH (RAND_W),
      .TAP   (RAND_TAP),
      .SEED  (RAND_SEED)
   ) i_rand (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (sym_en && mode_sel == MODE_RAND),
      .restart (chg),
      .sym     (rand_sym)
   );

   // jitter pattern: -1 first, then alternate
   assign jit_sym = (chg ? 1'b0 : jit_tog) ? SYM_POS : SYM_NEG;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         jit_tog <= 1'b0;
      else if (sym_en && mode_sel == MODE_JITTER)
         jit_tog <= chg ? 1'b1 : ~jit_tog;
   end

   always_comb begin
      case (mode_sel)
         MODE_PASS:   nxt_sym = data_in;
         MODE_DROOP:  nxt_sym = droop_sym;
         MODE_JITTER: nxt_sym = jit_sym;
         MODE_DIST:   nxt_sym = dist_sym;
         MODE_RAND:   nxt_sym = rand_sym;
         default:     nxt_sym = SYM_ZERO;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_out <= SYM_ZERO;
         mode_q  <= MODE_PASS;
         sym_vld <= 1'b0;
      end else begin
         sym_vld <= sym_en;
         if (sym_en) begin
            sym_out <= nxt_sym;
            mode_q  <= mode_sel;
         end
      end
   end

   AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      sym_en |=> sym_vld); // R2

   AST_NO_VLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_en |=> !sym_vld); // R2

   AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_en |=> $stable(sym_out)); // R2

   AST_TEST_SYM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_PASS) |-> (sym_out != 2'b10)); // R3

   AST_PASS_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_en && mode_sel == MODE_PASS) |=> sym_out == $past(data_in)); // R4

   AST_JITTER_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_en && mode_sel == MODE_JITTER && mode_q == MODE_JITTER)
         |=> sym_out != $past(sym_out)); // R6

   AST_UNUSED_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_en && (mode_sel == 3'd3 || mode_sel == 3'd6 || mode_sel == 3'd7))
         |=> sym_out == SYM_ZERO); // R9

   AST_JITTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_en && mode_sel == MODE_JITTER && mode_q != MODE_JITTER)
         |=> sym_out == SYM_NEG); // R10

   AST_DROOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_en && mode_sel == MODE_DROOP && mode_q != MODE_DROOP)
         |=> sym_out == SYM_POS); // R10

endmodule

// File: tb/test_pam3_tx_pattern_gen.sv
module test_pam3_tx_pattern_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sym_en = 1'b0;
   logic [2:0] mode_sel = 3'd0;
   logic [1:0] data_in = 2'b00;
   logic [1:0] sym_out;
   logic       sym_vld;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   localparam logic [1:0] P1 = 2'b01;
   localparam logic [1:0] Z0 = 2'b00;
   localparam logic [1:0] M1 = 2'b11;

   logic [1:0] cap [0:2199];

   always #10 clk = ~clk;

   pam3_tx_pattern_gen i_pam3_tx_pattern_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym_en   (sym_en),
      .mode_sel (mode_sel),
      .data_in  (data_in),
      .sym_out  (sym_out),
      .sym_vld  (sym_vld)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [1:0] map2(input logic [1:0] b);
      case (b)
         2'b01:   return P1;
         2'b10:   return M1;
         default: return Z0;
      endcase
   endfunction

   function automatic logic [10:0] nx11(input logic [10:0] s);
      return {s[9:0], s[10] ^ s[8]};
   endfunction

   function automatic logic [32:0] nx33(input logic [32:0] s);
      return {s[31:0], s[32] ^ s[19]};
   endfunction

   // one strobe, entered and left at a falling edge
   task automatic strobe(output logic [1:0] s);
      sym_en = 1'b1;
      @(negedge clk);
      s = sym_out;
      sym_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(sym_out == Z0, "R1 out during reset", sym_out, Z0);
      chk(sym_vld == 1'b0, "R1 vld during reset", sym_vld, 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      chk(sym_out == Z0 && sym_vld == 1'b0, "R1 after release", {sym_vld, sym_out}, 0);
   endtask

   task automatic t_pass;
      logic [1:0] s;
      int errs = 0;
      mode_sel = 3'd0;
      for (int k = 0; k < 8; k++) begin
         data_in = 2'(k * 3 + 1);
         strobe(s);
         if (s !== data_in) errs++;
      end
      chk(errs == 0, "R4 pass-through", errs, 0);
   endtask

   task automatic t_hold;
      logic [1:0] s;
      mode_sel = 3'd0;
      data_in  = P1;
      sym_en   = 1'b1;
      @(negedge clk);
      chk(sym_vld == 1'b1 && sym_out == P1, "R2 valid after strobe", {sym_vld, sym_out}, 3'b101);
      sym_en  = 1'b0;
      data_in = M1;
      idle(3);
      chk(sym_out == P1, "R2 hold without strobe", sym_out, P1);
      chk(sym_vld == 1'b0, "R2 valid low without strobe", sym_vld, 0);
      strobe(s);
      chk(s == M1, "R2 next strobe loads", s, M1);
   endtask

   task automatic t_droop;
      logic [1:0] s;
      int errs = 0;
      int first_bad = -1;
      logic [1:0] exp_s;
      mode_sel = 3'd1;
      for (int k = 0; k < 3 * 68; k++) begin
         strobe(s);
         exp_s = ((k % 68) < 34) ? P1 : M1;
         if (s !== exp_s) begin
            errs++;
            if (first_bad < 0) first_bad = k;
         end
         if (k % 17 == 5) idle(k % 4); // R11 irregular gaps
      end
      chk(errs == 0, "R5 droop runs of 34 with gaps R11", errs, first_bad);
   endtask

   task automatic t_jitter;
      logic [1:0] s;
      int errs = 0;
      mode_sel = 3'd2;
      for (int k = 0; k < 40; k++) begin
         strobe(s);
         if (s !== ((k % 2 == 0) ? M1 : P1)) errs++;
         if (k == 9) idle(5);
      end
      chk(errs == 0, "R6 jitter alternation", errs, 0);
   endtask

   task automatic t_dist;
      logic [10:0] m = 11'h001;
      logic [1:0] s;
      int errs = 0;
      int per_errs = 0;
      int illegal = 0;
      mode_sel = 3'd4;
      for (int k = 0; k < 2047 + 64; k++) begin
         strobe(s);
         cap[k] = s;
         if (s !== map2(m[1:0])) errs++;
         if (s == 2'b10) illegal++;
         m = nx11(m);
      end
      for (int k = 0; k < 64; k++)
         if (cap[k] !== cap[k + 2047]) per_errs++;
      chk(errs == 0, "R7 distortion sequence", errs, 0);
      chk(per_errs == 0, "R7 period 2047", per_errs, 0);
      chk(illegal == 0, "R3 no 2'b10 in test mode", illegal, 0);
   endtask

   task automatic t_rand;
      logic [32:0] m = 33'h1;
      logic [1:0] s;
      int errs = 0;
      int diffs = 0;
      mode_sel = 3'd5;
      for (int k = 0; k < 2047 + 150; k++) begin
         strobe(s);
         cap[k] = s;
         if (s !== map2(m[1:0])) errs++;
         m = nx33(m);
      end
      for (int k = 0; k < 150; k++)
         if (cap[k] !== cap[k + 2047]) diffs++;
      chk(errs == 0, "R8 random sequence", errs, 0);
      chk(diffs > 0, "R8 no 2047 period", diffs, 1);
   endtask

   task automatic t_unused;
      logic [1:0] s;
      int errs = 0;
      logic [2:0] codes [3] = '{3'd3, 3'd6, 3'd7};
      foreach (codes[i]) begin
         mode_sel = 3'd2;
         strobe(s);
         mode_sel = codes[i];
         for (int k = 0; k < 5; k++) begin
            data_in = P1;
            strobe(s);
            if (s !== Z0) errs++;
         end
      end
      chk(errs == 0, "R9 unused codes give 0", errs, 0);
   endtask

   task automatic t_switch;
      logic [1:0] s;
      logic [1:0] prev;
      int errs = 0;
      mode_sel = 3'd1;
      for (int k = 0; k < 10; k++) strobe(s);
      mode_sel = 3'd2;
      strobe(s);
      chk(s == M1, "R10 jitter restarts at -1", s, M1);
      strobe(s);
      mode_sel = 3'd1;
      for (int k = 0; k < 40; k++) begin
         strobe(s);
         if (s !== ((k < 34) ? P1 : M1)) errs++;
      end
      chk(errs == 0, "R10 droop restarts from start", errs, 0);
      mode_sel = 3'd2;
      strobe(prev);
      strobe(prev);
      mode_sel = 3'd5;
      idle(2);
      mode_sel = 3'd2;
      strobe(s);
      chk(s == ((prev == P1) ? M1 : P1), "R10 withdrawn code ignored", s, (prev == P1) ? M1 : P1);
   endtask

   initial begin
      idle(3);
      t_reset;
      t_pass;
      t_hold;
      t_droop;
      t_jitter;
      t_dist;
      t_rand;
      t_unused;
      t_switch;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule